// File: doc/BRIEF.md
# Three-Ring Round-Robin Transmit Scheduler

This block sits in front of a shared transmit port that carries two protocols: framed cell traffic and SPI-4.2 bursts. Writers push words into three rings, one for data frames, one for bursts and one for control frames. Each word carries an end-of-element mark. A round-robin arbiter picks which ring goes next, and the scheduler streams the chosen element out word by word. The element leaves whole, with no break, and a protocol flag on every output word says which protocol it belongs to.

The two protocols handle an empty slot differently. Frame traffic must keep refreshing the link-level flow-control state. So when neither frame ring holds a complete element, the data-frame turn is filled with an idle frame that carries the flow-control input bits. Burst traffic gets no filler. An empty burst ring simply loses its turn.

The three ring depths keep a fixed 4:3:1 ratio (data : burst : control) of a parameter `UNIT`. An element becomes eligible only once its final word has been written.

Top module: `tri_ring_tx_sched`

## Requirements
- R1: While `rst_n` is low, `tx_valid` is 0 and all three full flags are 0, and the rings are emptied.
- R2: The data ring holds 4*UNIT words, the burst ring 3*UNIT and the control ring UNIT. A ring's full flag is 1 exactly when that many words are stored.
- R3: A write presented while its ring is full is dropped, and its word never appears on `tx_data`.
- R4: Within a ring, words leave in write order. A ring is considered only once an element's last word (`*_wr_last`=1) is stored. An element is sent on consecutive cycles from first word to `tx_last`=1, and no arbitration happens inside it.
- R5: At each element boundary the arbiter scans from its pointer in the order data(0) → burst(1) → control(2) → data. It serves the first candidate and moves the pointer to the ring after the one served. Rings with no candidate are skipped within the same decision cycle.
- R6: When neither the data nor the control ring holds a complete element, the data ring's turn is taken by an idle frame of IDLE_LEN words, marked `tx_src`=3. No idle frame is sent while either frame ring holds a complete element.
- R7: Every word of an idle frame carries `fc_status`, zero-extended into the low bits of `tx_data`, as sampled in the decision cycle that starts the frame. The value is held for the whole frame.
- R8: No filler is ever produced for bursts. `tx_src`=1 appears only for words that were written into the burst ring, and an empty burst ring's turn is skipped.
- R9: `tx_proto` is 0 on burst words (`tx_src`=1) and 1 on data (`tx_src`=0), control (`tx_src`=2) and idle (`tx_src`=3) words.
- R10: The output is registered. A word chosen in one cycle appears on `tx_*` after the next rising edge. From the first edge after reset `tx_valid` stays 1, because an idle frame is always available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_status | input | FCW | Flow-control state carried by idle frames |
| dat_wr_en | input | 1 | Data-frame ring write strobe |
| dat_wr_data | input | W | Data-frame ring write word |
| dat_wr_last | input | 1 | Marks final word of a data frame |
| dat_full | output | 1 | Data-frame ring full |
| brs_wr_en | input | 1 | Burst ring write strobe |
| brs_wr_data | input | W | Burst ring write word |
| brs_wr_last | input | 1 | Marks final word of a burst |
| brs_full | output | 1 | Burst ring full |
| ctl_wr_en | input | 1 | Control-frame ring write strobe |
| ctl_wr_data | input | W | Control-frame ring write word |
| ctl_wr_last | input | 1 | Marks final word of a control frame |
| ctl_full | output | 1 | Control-frame ring full |
| tx_valid | output | 1 | Output word valid |
| tx_data | output | W | Output word |
| tx_last | output | 1 | Final word of the current element |
| tx_proto | output | 1 | 0 for burst words, 1 for frame-protocol words |
| tx_src | output | 2 | Source: 0 data, 1 burst, 2 control, 3 idle |

## Verification
The bench drives a control frame into its ring while a long data frame holds the port, so later control writes meet a full ring. A design that accepted them, or counted full one word late, would emit extra control words. The `fc_status` input changes on every cycle during idle frames, which catches a design that samples it per word instead of once at the start. Burst-only traffic checks that the burst turn never produces a filler word and that idle frames alternate with bursts. A design that fed bursts with idle control words, or never refreshed flow control, would be caught here. Mixed random traffic with partial elements, plus a reset in the middle of a run, exercises skip-in-one-cycle arbitration and whole-element transmission, where a wrong pointer update or a boundary split shows up as a source or data mismatch.

// File: rtl/tsched_pkg.sv
`timescale 1ns/1ps
package tsched_pkg;

  typedef enum logic [1:0] {
    SRC_DATA  = 2'd0,
    SRC_BURST = 2'd1,
    SRC_CTRL  = 2'd2,
    SRC_IDLE  = 2'd3
  } tx_src_e;

  localparam int NUM_RINGS = 3;

  // Ring depth in words, 4:3:1 share of the unit size.
  function automatic int ring_depth(input int unit, input int ring);
    case (ring)
      0:       return 4 * unit;
      1:       return 3 * unit;
      default: return unit;
    endcase
  endfunction

  // Successor in the service cycle 0 -> 1 -> 2 -> 0.
  function automatic logic [1:0] ring_after(input logic [1:0] r);
    return (r >= 2'd2) ? 2'd0 : r + 2'd1;
  endfunction

  // First candidate found when scanning from start.
  function automatic logic [1:0] rr_pick(input logic [2:0] cand, input logic [1:0] start);
    logic [3:0] c4;
    logic [1:0] idx;
    logic [1:0] pick;
    logic       hit;
    c4   = {1'b0, cand};
    idx  = start;
    pick = start;
    hit  = 1'b0;
    for (int k = 0; k < NUM_RINGS; k++) begin
      if (!hit && c4[idx]) begin
        pick = idx;
        hit  = 1'b1;
      end
      idx = ring_after(idx);
    end
    return pick;
  endfunction

  function automatic logic proto_of(input tx_src_e s);
    return s != SRC_BURST;
  endfunction

endpackage

// File: rtl/tsched_ring.sv
`timescale 1ns/1ps
module tsched_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         wr_last,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] rd_data,
  output logic         rd_last,
  output logic         has_elem
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W:0]    store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] words, elems;
  logic          accept, push_end, pop_end;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full     = (words == CW'(DEPTH));
  assign accept   = wr_en && !full;
  assign rd_data  = store[rp][W-1:0];
  assign rd_last  = store[rp][W];
  assign has_elem = (elems != '0);
  assign push_end = accept && wr_last;
  assign pop_end  = pop && rd_last;

  always_ff @(posedge clk) begin
    if (accept) store[wp] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      words <= '0;
      elems <= '0;
    end else begin
      if (accept) wp <= bump(wp);
      if (pop)    rp <= bump(rp);
      words <= words + CW'(accept) - CW'(pop);
      elems <= elems + CW'(push_end) - CW'(pop_end);
    end
  end

  // R3: a write into a full ring leaves the occupancy no higher
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> (words <= $past(words)));

  // R2: occupancy never exceeds the ring size
  assert_depth_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    words <= CW'(DEPTH));

  // R4: reads only happen inside a complete element
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (elems != '0 && words != '0));

endmodule

// File: rtl/tsched_arb.sv
`timescale 1ns/1ps
module tsched_arb
  import tsched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] has_elem,
  input  logic       advance,
  output logic [2:0] grant,
  output logic [1:0] pick_idx,
  output logic       idle_pick
);
  logic [1:0] ptr;
  logic       frames_dry;
  logic [2:0] cand;

  assign frames_dry = !has_elem[SRC_DATA] && !has_elem[SRC_CTRL];
  assign cand       = {has_elem[SRC_CTRL], has_elem[SRC_BURST],
                       has_elem[SRC_DATA] | frames_dry};
  assign pick_idx   = rr_pick(cand, ptr);
  assign grant      = 3'b001 << pick_idx;
  assign idle_pick  = (pick_idx == 2'd0) && !has_elem[SRC_DATA];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= 2'd0;
    else if (advance) ptr <= ring_after(pick_idx);
  end

  // R5: a served ring really held a complete element
  assert_skip_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !idle_pick) |-> has_elem[pick_idx]);

  // R8: the burst slot is never granted without burst data
  assert_no_burst_filler_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant[1] |-> has_elem[1]);

  // R6: idle frame only when both frame rings are dry
  assert_idle_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && idle_pick) |-> (!has_elem[0] && !has_elem[2]));

endmodule

// File: rtl/tsched_idle.sv
`timescale 1ns/1ps
module tsched_idle #(
  parameter int W        = 32,
  parameter int FCW      = 2,
  parameter int IDLE_LEN = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FCW-1:0] fc_in,
  input  logic           start,
  input  logic           step,
  output logic [W-1:0]   word,
  output logic           last
);
  localparam int CW = $clog2(IDLE_LEN + 1);

  logic [FCW-1:0] hold;
  logic [CW-1:0]  cnt;

  assign word = W'(start ? fc_in : hold);
  assign last = start ? (IDLE_LEN == 1) : (cnt == CW'(IDLE_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      cnt  <= '0;
    end else if (start) begin
      hold <= fc_in;
      cnt  <= CW'(1);
    end else if (step) begin
      cnt <= cnt + CW'(1);
    end
  end

  // R6: an idle frame never runs past its length
  assert_idle_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt < CW'(IDLE_LEN)));

endmodule

// File: rtl/tri_ring_tx_sched.sv
`timescale 1ns/1ps
module tri_ring_tx_sched
  import tsched_pkg::*;
#(
  parameter int W        = 32,
  parameter int FCW      = 2,
  parameter int UNIT     = 4,
  parameter int IDLE_LEN = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FCW-1:0] fc_status,
  input  logic           dat_wr_en,
  input  logic [W-1:0]   dat_wr_data,
  input  logic           dat_wr_last,
  output logic           dat_full,
  input  logic           brs_wr_en,
  input  logic [W-1:0]   brs_wr_data,
  input  logic           brs_wr_last,
  output logic           brs_full,
  input  logic           ctl_wr_en,
  input  logic [W-1:0]   ctl_wr_data,
  input  logic           ctl_wr_last,
  output logic           ctl_full,
  output logic           tx_valid,
  output logic [W-1:0]   tx_data,
  output logic           tx_last,
  output logic           tx_proto,
  output logic [1:0]     tx_src
);
  logic [2:0]   wen, wlast, full_v, pop_v, rlast_v, has_v;
  logic [W-1:0] wd [NUM_RINGS];
  logic [W-1:0] rd [NUM_RINGS];

  assign wen   = {ctl_wr_en, brs_wr_en, dat_wr_en};
  assign wlast = {ctl_wr_last, brs_wr_last, dat_wr_last};
  assign wd[0] = dat_wr_data;
  assign wd[1] = brs_wr_data;
  assign wd[2] = ctl_wr_data;
  assign dat_full = full_v[0];
  assign brs_full = full_v[1];
  assign ctl_full = full_v[2];

  generate
    for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
      tsched_ring #(.W(W), .DEPTH(ring_depth(UNIT, i))) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wen[i]),
        .wr_data  (wd[i]),
        .wr_last  (wlast[i]),
        .pop      (pop_v[i]),
        .full     (full_v[i]),
        .rd_data  (rd[i]),
        .rd_last  (rlast_v[i]),
        .has_elem (has_v[i])
      );
    end
  endgenerate

  // element-boundary state
  logic    busy;
  tx_src_e cur;
  logic    decide;
  assign decide = !busy;

  logic [2:0] grant;
  logic [1:0] pick_idx;
  logic       idle_pick;

  tsched_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .has_elem  (has_v),
    .advance   (decide),
    .grant     (grant),
    .pick_idx  (pick_idx),
    .idle_pick (idle_pick)
  );

  logic         idle_start, idle_step, idle_last;
  logic [W-1:0] idle_word;

  tsched_idle #(.W(W), .FCW(FCW), .IDLE_LEN(IDLE_LEN)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .fc_in (fc_status),
    .start (idle_start),
    .step  (idle_step),
    .word  (idle_word),
    .last  (idle_last)
  );

  tx_src_e      sel_src;
  logic [W-1:0] sel_word;
  logic         sel_last;

  always_comb begin
    idle_start = 1'b0;
    idle_step  = 1'b0;
    if (decide) begin
      if (idle_pick) begin
        sel_src    = SRC_IDLE;
        idle_start = 1'b1;
      end else begin
        sel_src = tx_src_e'(pick_idx);
      end
    end else begin
      sel_src   = cur;
      idle_step = (cur == SRC_IDLE);
    end
    for (int i = 0; i < NUM_RINGS; i++)
      pop_v[i] = (2'(sel_src) == 2'(i));
    case (sel_src)
      SRC_DATA:  begin sel_word = rd[0];     sel_last = rlast_v[0]; end
      SRC_BURST: begin sel_word = rd[1];     sel_last = rlast_v[1]; end
      SRC_CTRL:  begin sel_word = rd[2];     sel_last = rlast_v[2]; end
      default:   begin sel_word = idle_word; sel_last = idle_last;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur      <= SRC_DATA;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
      tx_proto <= 1'b0;
      tx_src   <= 2'd0;
    end else begin
      busy     <= !sel_last;
      cur      <= sel_src;
      tx_valid <= 1'b1;
      tx_data  <= sel_word;
      tx_last  <= sel_last;
      tx_proto <= proto_of(sel_src);
      tx_src   <= 2'(sel_src);
    end
  end

  // R4: an unfinished element continues from the same source
  assert_whole_element_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_last) |=> (tx_valid && tx_src == $past(tx_src)));

  // R7: idle payload is held across the frame
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && $past(tx_valid) && tx_src == 2'd3 && !$past(tx_last))
      |-> (tx_data == $past(tx_data)));

  // R9: protocol flag agrees with the source code
  assert_proto_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_proto == (tx_src != 2'd1)));

  // R10: the port never goes quiet once running
  assert_streaming_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_valid) |-> tx_valid);

endmodule

// File: tb/tri_ring_tx_sched_test.sv
`timescale 1ns/1ps
module tri_ring_tx_sched_test;
  localparam int W = 32, FCW = 2, UNIT = 4, IDLE_LEN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FCW-1:0] fc = '0;
  logic [2:0] wen = '0, wlast = '0;
  logic [W-1:0] wdat [3];
  logic dat_full, brs_full, ctl_full;
  logic tx_valid, tx_last, tx_proto;
  logic [W-1:0] tx_data;
  logic [1:0] tx_src;

  always #2.5 clk = ~clk;

  tri_ring_tx_sched #(.W(W), .FCW(FCW), .UNIT(UNIT), .IDLE_LEN(IDLE_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .fc_status(fc),
    .dat_wr_en(wen[0]), .dat_wr_data(wdat[0]), .dat_wr_last(wlast[0]), .dat_full(dat_full),
    .brs_wr_en(wen[1]), .brs_wr_data(wdat[1]), .brs_wr_last(wlast[1]), .brs_full(brs_full),
    .ctl_wr_en(wen[2]), .ctl_wr_data(wdat[2]), .ctl_wr_last(wlast[2]), .ctl_full(ctl_full),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_proto(tx_proto), .tx_src(tx_src)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  logic [W:0] q0[$], q1[$], q2[$];
  int ecnt [3];
  int mptr, msrc, midle;
  bit mbusy;
  logic [FCW-1:0] mfc;
  bit e_valid, e_last;
  logic [W-1:0] e_data;
  int e_src;
  int acc_brs = 0, out_brs = 0, ctl_out = 0;

  function automatic int depth_of(input int i);
    return (i == 0) ? 4 * UNIT : (i == 1) ? 3 * UNIT : UNIT;
  endfunction

  function automatic int qsize(input int i);
    return (i == 0) ? q0.size() : (i == 1) ? q1.size() : q2.size();
  endfunction

  function automatic logic [W:0] qpop(input int i);
    if (i == 0) return q0.pop_front();
    if (i == 1) return q1.pop_front();
    return q2.pop_front();
  endfunction

  function automatic void qpush(input int i, input logic [W:0] v);
    if (i == 0) q0.push_back(v);
    else if (i == 1) q1.push_back(v);
    else q2.push_back(v);
  endfunction

  task automatic model_reset();
    q0.delete(); q1.delete(); q2.delete();
    for (int i = 0; i < 3; i++) ecnt[i] = 0;
    mptr = 0; msrc = 0; midle = 0; mbusy = 0; mfc = '0;
    e_valid = 0; e_last = 0; e_data = '0; e_src = 0;
  endtask

  task automatic model_step();
    bit acc [3];
    bit cand [3];
    bit has0, has2;
    logic [W:0] w;
    int s;
    for (int i = 0; i < 3; i++) acc[i] = wen[i] && (qsize(i) < depth_of(i));
    if (!mbusy) begin
      has0 = ecnt[0] > 0;
      has2 = ecnt[2] > 0;
      cand[0] = has0 || (!has0 && !has2);
      cand[1] = ecnt[1] > 0;
      cand[2] = has2;
      s = -1;
      for (int k = 0; k < 3; k++)
        if (s < 0 && cand[(mptr + k) % 3]) s = (mptr + k) % 3;
      mptr = (s + 1) % 3;
      if (s == 0 && !has0) begin
        e_src = 3; mfc = fc; e_data = W'(fc); midle = 1;
        e_last = (midle == IDLE_LEN);
      end else begin
        w = qpop(s); e_data = w[W-1:0]; e_last = w[W]; e_src = s;
        if (e_last) ecnt[s]--;
      end
    end else if (msrc == 3) begin
      e_src = 3; e_data = W'(mfc); midle++;
      e_last = (midle == IDLE_LEN);
    end else begin
      w = qpop(msrc); e_data = w[W-1:0]; e_last = w[W]; e_src = msrc;
      if (e_last) ecnt[msrc]--;
    end
    msrc = e_src; mbusy = !e_last; e_valid = 1;
    for (int i = 0; i < 3; i++)
      if (acc[i]) begin
        qpush(i, {wlast[i], wdat[i]});
        if (wlast[i]) ecnt[i]++;
        if (i == 1) acc_brs++;
      end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    string stag;
    if (rst_n && !done) begin
      chk("R10", "tx_valid", tx_valid, e_valid);
      if (e_valid) begin
        chk(e_src == 3 ? "R7" : "R4", "tx_data", tx_data, e_data);
        chk("R4", "tx_last", tx_last, e_last);
        stag = (e_src == 3 || tx_src == 3) ? "R6" :
               (e_src == 1 || tx_src == 1) ? "R8" : "R5";
        chk(stag, "tx_src", tx_src, e_src);
        chk("R9", "tx_proto", tx_proto, e_src != 1);
      end
      chk("R2", "dat_full", dat_full, qsize(0) == depth_of(0));
      chk("R2", "brs_full", brs_full, qsize(1) == depth_of(1));
      chk("R2", "ctl_full", ctl_full, qsize(2) == depth_of(2));
      if (tx_valid && tx_src == 2'd1) out_brs++;
      if (tx_valid && tx_src == 2'd2) ctl_out++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc();
    @(negedge clk);
    wen = '0;
    wlast = '0;
  endtask

  task automatic put(input int i, input logic [W-1:0] d, input bit last);
    wen[i] = 1'b1; wdat[i] = d; wlast[i] = last;
  endtask

  task automatic send_elem(input int i, input int len, input logic [15:0] tag);
    for (int k = 0; k < len; k++) begin
      cyc();
      put(i, {tag, 16'(k)}, k == len - 1);
    end
  endtask

  int plen [3];
  int ppos [3];

  initial begin
    for (int i = 0; i < 3; i++) wdat[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "tx_valid in reset", tx_valid, 0);
    chk("R1", "full flags in reset", {dat_full, brs_full, ctl_full}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // idle frames only, flow-control bits change each cycle (R6, R7)
    for (int n = 0; n < 14; n++) begin
      cyc();
      fc = FCW'(n);
    end

    // bursts only: no burst filler, idles interleave (R8)
    send_elem(1, 3, 16'hB001);
    send_elem(1, 2, 16'hB002);
    repeat (20) cyc();

    // all three rings at once, single-word elements (R5)
    cyc();
    put(0, 32'hD0D0_0001, 1'b1);
    put(1, 32'hB0B0_0001, 1'b1);
    put(2, 32'hC0C0_0001, 1'b1);
    repeat (12) cyc();

    // overflow of the control ring behind a long data frame (R3)
    ctl_out = 0;
    send_elem(0, 10, 16'hDA7A);
    for (int k = 0; k < 7; k++) begin
      cyc();
      if (k == 4) chk("R2", "ctl_full after four words", ctl_full, 1);
      put(2, {16'hC7C7, 16'(k)}, k == 3 || k == 6);
    end
    repeat (40) cyc();
    chk("R3", "control words sent after overflow", ctl_out, 4);

    // mixed random traffic
    for (int i = 0; i < 3; i++) begin plen[i] = 1 + ($urandom % 4); ppos[i] = 0; end
    for (int n = 0; n < 3000; n++) begin
      cyc();
      fc = FCW'($urandom);
      for (int i = 0; i < 3; i++)
        if (($urandom % 100) < ((i == 2) ? 12 : 28)) begin
          put(i, {4'(i), 12'(n), 16'(ppos[i])}, ppos[i] == plen[i] - 1);
          ppos[i]++;
          if (ppos[i] == plen[i]) begin ppos[i] = 0; plen[i] = 1 + ($urandom % 4); end
        end
    end
    repeat (300) cyc();
    chk("R8", "burst words out vs accepted", out_brs, acc_brs - q1.size());

    // reset in the middle of traffic (R1)
    send_elem(0, 3, 16'hE001);
    cyc();
    rst_n = 1'b0;
    #1;
    chk("R1", "tx_valid after mid-run reset", tx_valid, 0);
    chk("R1", "full flags after mid-run reset", {dat_full, brs_full, ctl_full}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    send_elem(2, 2, 16'hF00D);
    repeat (20) cyc();
    report();
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

endmodule